// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block keeps every in-flight store of an out-of-order core in program order, from the moment the store is dispatched until it retires. Dispatch reserves the slot at the queue tail and hands its index back. When the store executes, its address and data land in that reserved slot. At retirement the oldest entry is handed to the data cache and its slot is released. Because of this, memory sees stores strictly in program order.

A load records the queue's tail position when it is dispatched. Later, it presents its address together with that recorded position to a combinational search port. The search looks only at entries that were allocated before that position. Among those with an equal address, it returns the youngest one's data. If nothing matches, the load uses the cache value.

The mode pin picks how older entries whose address is still unknown are handled:
- In conservative mode they stall the load.
- In opportunistic mode the search skips over them.

A clear input empties the whole queue in one cycle.

Top module: `store_queue`

## Requirements
- R1: When `disp_valid` and `disp_ready` are both high at a clock edge, the entry at the tail is reserved. `disp_idx` shows that slot's index in the cycle before the edge, and the tail then advances by one, modulo DEPTH. `disp_ready` is low while DEPTH entries are held, and a request made then changes nothing.
- R2: An `exec_valid` cycle that addresses a reserved slot whose address is still unknown writes `exec_addr` and `exec_data` into that slot and marks its address known.
- R3: `dc_valid` is high exactly when `retire_ok` is high, the queue is not empty, and the head entry's address is known. `dc_addr` and `dc_data` then show the head entry. The head is freed on a cycle where `dc_valid` and `dc_ready` are both high. While `dc_ready` is low, the offered address and data stay unchanged, so drains come out in dispatch order.
- R4: `ld_pos` is a tail snapshot that carries a wrap bit. An entry counts as older than the load only if it is reserved and its distance from the head is less than `ld_pos` minus the head pointer. Entries that are not older never match.
- R5: When more than one older, known entry has an address equal to `ld_addr`, `ld_data` comes from the youngest of them and `ld_hit` is 1.
- R6: With no older, known entry at an equal address, and no stall, `ld_hit` is 0 and `ld_data` is 0.
- R7: With `mode_opp` = 0 (conservative), any older entry whose address is unknown drives `ld_stall` to 1 and forces `ld_hit` to 0.
- R8: With `mode_opp` = 1 (opportunistic), `ld_stall` is 0 and older unknown-address entries are skipped by the search.
- R9: Pointers are one bit wider than the slot index, so age order and full/empty stay correct after the queue wraps.
- R10: A high `clear` at a clock edge empties every entry and returns both pointers to 0. After that edge, `disp_ready` is 1 and `dc_valid` is 0.
- R11: After reset the queue is empty: `disp_ready` is 1, `dc_valid` is 0 and `disp_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Empty the whole queue at the next edge |
| mode_opp | input | 1 | 0 = conservative, 1 = opportunistic search |
| disp_valid | input | 1 | Store dispatch request |
| disp_ready | output | 1 | Queue can take a store (not full) |
| disp_idx | output | IDXW | Slot the next dispatched store receives |
| disp_pos | output | IDXW+1 | Tail pointer with wrap bit; loads record this as their position |
| exec_valid | input | 1 | Store execute write strobe |
| exec_slot | input | IDXW | Slot being written |
| exec_addr | input | AW | Store address |
| exec_data | input | DW | Store data |
| retire_ok | input | 1 | Head store is allowed to retire |
| dc_valid | output | 1 | Cache write offered |
| dc_ready | input | 1 | Cache accepts the write |
| dc_addr | output | AW | Head store address |
| dc_data | output | DW | Head store data |
| ld_addr | input | AW | Load search address |
| ld_pos | input | IDXW+1 | Load's recorded tail snapshot |
| ld_hit | output | 1 | Forwarding hit |
| ld_stall | output | 1 | Load must wait (conservative mode only) |
| ld_data | output | DW | Forwarded store data |

## Verification
Five stores are set up with three aliases on one address and one entry left unexecuted. Loads then probe this set from several recorded positions, which separates the age bound from a plain address match. Probing the same address from widening positions tells youngest-older selection apart from oldest or any-match selection. Each position is tried in both modes, which shows a stall on an unknown older address apart from a skip over it. A second round on a full, wrapped queue checks age order across the wrap bit. Drains under held-off cache acceptance, and with an unknown head address, show the retire handshake and its ordering.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic {
    SQ_CONSERVATIVE  = 1'b0,
    SQ_OPPORTUNISTIC = 1'b1
  } sq_mode_e;
endpackage

// File: rtl/sq_ptr_ctrl.sv
module sq_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            push,
  input  logic            pop,
  output logic [PTRW-1:0] head_ptr,
  output logic [PTRW-1:0] tail_ptr,
  output logic            full,
  output logic            empty
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
    end else if (clear) begin
      head_ptr <= '0;
      tail_ptr <= '0;
    end else begin
      if (push) tail_ptr <= tail_ptr + 1'b1;
      if (pop)  head_ptr <= head_ptr + 1'b1;
    end
  end

  // same slot index, opposite lap bit => full
  assign full  = (head_ptr[IDXW-1:0] == tail_ptr[IDXW-1:0]) &&
                 (head_ptr[IDXW] != tail_ptr[IDXW]);
  assign empty = (head_ptr == tail_ptr);
endmodule

// File: rtl/sq_store_array.sv
module sq_store_array #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     push,
  input  logic [IDXW-1:0]          push_slot,
  input  logic                     wr_en,
  input  logic [IDXW-1:0]          wr_slot,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     pop,
  input  logic [IDXW-1:0]          pop_slot,
  output logic [DEPTH-1:0]         used,
  output logic [DEPTH-1:0]         known,
  output logic [DEPTH-1:0][AW-1:0] addr_q,
  output logic [DEPTH-1:0][DW-1:0] data_q
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        used[i]  <= 1'b0;
        known[i] <= 1'b0;
      end else if (clear) begin
        used[i]  <= 1'b0;
        known[i] <= 1'b0;
      end else if (push && push_slot == IDXW'(i)) begin
        used[i]  <= 1'b1;
        known[i] <= 1'b0;
      end else if (pop && pop_slot == IDXW'(i)) begin
        used[i]  <= 1'b0;
        known[i] <= 1'b0;
      end else if (wr_en && wr_slot == IDXW'(i)) begin
        known[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_slot == IDXW'(i)) begin
        addr_q[i] <= wr_addr;
        data_q[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/sq_fwd_search.sv
module sq_fwd_search
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1
) (
  input  logic [PTRW-1:0]          head_ptr,
  input  logic [DEPTH-1:0]         used,
  input  logic [DEPTH-1:0]         known,
  input  logic [DEPTH-1:0][AW-1:0] addr_q,
  input  logic [DEPTH-1:0][DW-1:0] data_q,
  input  sq_mode_e                 mode,
  input  logic [AW-1:0]            ld_addr,
  input  logic [PTRW-1:0]          ld_pos,
  output logic                     hit,
  output logic                     stall,
  output logic [DW-1:0]            fwd_data
);
  logic [PTRW-1:0] older_cnt;
  logic            raw_hit;
  logic            unk_seen;
  logic [DW-1:0]   raw_data;

  assign older_cnt = ld_pos - head_ptr;

  // walk from oldest to youngest; a later match overwrites, so the
  // youngest older match is what remains
  always_comb begin
    logic [IDXW-1:0] s;
    raw_hit  = 1'b0;
    unk_seen = 1'b0;
    raw_data = '0;
    for (int j = 0; j < DEPTH; j++) begin
      s = head_ptr[IDXW-1:0] + IDXW'(j);
      if ((PTRW'(j) < older_cnt) && used[s]) begin
        if (!known[s]) begin
          unk_seen = 1'b1;
        end else if (addr_q[s] == ld_addr) begin
          raw_hit  = 1'b1;
          raw_data = data_q[s];
        end
      end
    end
  end

  assign stall    = (mode == SQ_CONSERVATIVE) && unk_seen;
  assign hit      = raw_hit && !stall;
  assign fwd_data = hit ? raw_data : '0;
endmodule

// File: rtl/store_queue.sv
module store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            mode_opp,
  input  logic            disp_valid,
  output logic            disp_ready,
  output logic [IDXW-1:0] disp_idx,
  output logic [PTRW-1:0] disp_pos,
  input  logic            exec_valid,
  input  logic [IDXW-1:0] exec_slot,
  input  logic [AW-1:0]   exec_addr,
  input  logic [DW-1:0]   exec_data,
  input  logic            retire_ok,
  output logic            dc_valid,
  input  logic            dc_ready,
  output logic [AW-1:0]   dc_addr,
  output logic [DW-1:0]   dc_data,
  input  logic [AW-1:0]   ld_addr,
  input  logic [PTRW-1:0] ld_pos,
  output logic            ld_hit,
  output logic            ld_stall,
  output logic [DW-1:0]   ld_data
);
  logic [PTRW-1:0]          head_ptr, tail_ptr;
  logic                     full, empty;
  logic                     push, pop, wr_en;
  logic [DEPTH-1:0]         used, known;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [IDXW-1:0]          head_idx;
  sq_mode_e                 mode;

  assign head_idx   = head_ptr[IDXW-1:0];
  assign disp_ready = !full;
  assign disp_idx   = tail_ptr[IDXW-1:0];
  assign disp_pos   = tail_ptr;
  assign push       = disp_valid && !full;
  assign wr_en      = exec_valid && used[exec_slot] && !known[exec_slot];
  assign dc_valid   = retire_ok && !empty && known[head_idx];
  assign pop        = dc_valid && dc_ready;
  assign dc_addr    = addr_q[head_idx];
  assign dc_data    = data_q[head_idx];
  assign mode       = mode_opp ? SQ_OPPORTUNISTIC : SQ_CONSERVATIVE;

  sq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clear(clear), .push(push), .pop(pop),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr), .full(full), .empty(empty)
  );

  sq_store_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_arr (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .push(push), .push_slot(tail_ptr[IDXW-1:0]),
    .wr_en(wr_en), .wr_slot(exec_slot), .wr_addr(exec_addr), .wr_data(exec_data),
    .pop(pop), .pop_slot(head_idx),
    .used(used), .known(known), .addr_q(addr_q), .data_q(data_q)
  );

  sq_fwd_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_srch (
    .head_ptr(head_ptr), .used(used), .known(known),
    .addr_q(addr_q), .data_q(data_q), .mode(mode),
    .ld_addr(ld_addr), .ld_pos(ld_pos),
    .hit(ld_hit), .stall(ld_stall), .fwd_data(ld_data)
  );
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clear,
  input logic            mode_opp,
  input logic            disp_valid,
  input logic            disp_ready,
  input logic [IDXW-1:0] disp_idx,
  input logic            dc_valid,
  input logic            dc_ready,
  input logic [AW-1:0]   dc_addr,
  input logic [DW-1:0]   dc_data,
  input logic            ld_hit,
  input logic            ld_stall
);
  p_dispatch_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && !clear) |=> disp_idx == IDXW'($past(disp_idx) + 1'b1))
    else $error("dispatch did not advance tail");

  p_dc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_valid && !dc_ready && !clear) |=> ($stable(dc_addr) && $stable(dc_data)))
    else $error("offered cache write changed under back-pressure");

  p_stall_nohit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> !ld_hit)
    else $error("hit reported while stalled");

  p_opp_nostall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_opp |-> !ld_stall)
    else $error("stall in opportunistic mode");

  p_clear_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (disp_ready && !dc_valid))
    else $error("queue not empty after clear");
endmodule

bind store_queue sq_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .mode_opp(mode_opp),
  .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_idx(disp_idx),
  .dc_valid(dc_valid), .dc_ready(dc_ready), .dc_addr(dc_addr), .dc_data(dc_data),
  .ld_hit(ld_hit), .ld_stall(ld_stall)
);

// File: tb/sim_store_queue.sv
module sim_store_queue;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int IDXW = 3;
  localparam int PTRW = 4;
  localparam int VW = 1 + AW + PTRW + 1 + 1 + DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, mode_opp = 1'b0, disp_valid = 1'b0;
  logic disp_ready;
  logic [IDXW-1:0] disp_idx;
  logic [PTRW-1:0] disp_pos;
  logic exec_valid = 1'b0;
  logic [IDXW-1:0] exec_slot = '0;
  logic [AW-1:0] exec_addr = '0;
  logic [DW-1:0] exec_data = '0;
  logic retire_ok = 1'b0, dc_ready = 1'b0;
  logic dc_valid;
  logic [AW-1:0] dc_addr;
  logic [DW-1:0] dc_data;
  logic [AW-1:0] ld_addr = '0;
  logic [PTRW-1:0] ld_pos = '0;
  logic ld_hit, ld_stall;
  logic [DW-1:0] ld_data;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (.*);

  // {mode, addr, pos, exp_hit, exp_stall, exp_data}
  localparam logic [VW-1:0] VEC [0:9] = '{
    {1'b0, 32'h100, 4'd1, 1'b1, 1'b0, 32'h11},
    {1'b0, 32'h100, 4'd3, 1'b1, 1'b0, 32'h33},
    {1'b0, 32'h300, 4'd3, 1'b0, 1'b0, 32'h0},
    {1'b0, 32'h100, 4'd0, 1'b0, 1'b0, 32'h0},
    {1'b0, 32'h100, 4'd4, 1'b0, 1'b1, 32'h0},
    {1'b1, 32'h100, 4'd4, 1'b1, 1'b0, 32'h33},
    {1'b1, 32'h100, 4'd5, 1'b1, 1'b0, 32'h55},
    {1'b1, 32'h200, 4'd5, 1'b1, 1'b0, 32'h22},
    {1'b0, 32'h100, 4'd5, 1'b0, 1'b1, 32'h0},
    {1'b0, 32'h200, 4'd2, 1'b1, 1'b0, 32'h22}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_exec(input logic [IDXW-1:0] s, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exec_valid = 1'b1; exec_slot = s; exec_addr = a; exec_data = d;
    step();
    exec_valid = 1'b0;
  endtask

  task automatic search(input string req, input logic m, input logic [AW-1:0] a,
                        input logic [PTRW-1:0] p, input logic eh, input logic es,
                        input logic [DW-1:0] ed);
    mode_opp = m; ld_addr = a; ld_pos = p;
    #1;
    chk({req, " hit"}, 64'(ld_hit), 64'(eh));
    chk({req, " stall"}, 64'(ld_stall), 64'(es));
    chk({req, " data"}, 64'(ld_data), 64'(ed));
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] exp_drain [5];
    exp_drain = '{32'h11, 32'h22, 32'h33, 32'h44, 32'h55};
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 ready", 64'(disp_ready), 64'd1);
    chk("R11 dc_valid", 64'(dc_valid), 64'd0);
    chk("R11 idx", 64'(disp_idx), 64'd0);

    // R1 dispatch five stores
    for (int i = 0; i < 5; i++) begin
      disp_valid = 1'b1;
      #1 chk("R1 idx", 64'(disp_idx), 64'(i));
      step();
    end
    disp_valid = 1'b0;

    // R2 execute four of them, slot 3 stays unknown
    do_exec(3'd0, 32'h100, 32'h11);
    do_exec(3'd1, 32'h200, 32'h22);
    do_exec(3'd2, 32'h100, 32'h33);
    do_exec(3'd4, 32'h100, 32'h55);

    // vector table: R4 R5 R6 R7 R8
    for (int v = 0; v < 10; v++) begin
      search("R4-R8 vec", VEC[v][VW-1], VEC[v][VW-2 -: AW], VEC[v][DW+2 +: PTRW],
             VEC[v][DW+1], VEC[v][DW], VEC[v][DW-1:0]);
    end

    // R2 late execute resolves slot 3
    do_exec(3'd3, 32'h200, 32'h44);
    search("R2 late", 1'b0, 32'h200, 4'd5, 1'b1, 1'b0, 32'h44);

    // R3 back-pressure then ordered drain
    retire_ok = 1'b1; dc_ready = 1'b0;
    #1 chk("R3 valid", 64'(dc_valid), 64'd1);
    chk("R3 addr", 64'(dc_addr), 64'h100);
    step();
    chk("R3 held", 64'(dc_data), 64'h11);
    chk("R3 held valid", 64'(dc_valid), 64'd1);
    dc_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      #1 chk("R3 order", 64'(dc_data), 64'(exp_drain[k]));
      step();
    end
    chk("R3 empty", 64'(dc_valid), 64'd0);

    // R3 unknown head blocks retirement
    disp_valid = 1'b1;
    #1 chk("R1 idx5", 64'(disp_idx), 64'd5);
    step();
    disp_valid = 1'b0;
    #1 chk("R3 unknown head", 64'(dc_valid), 64'd0);
    do_exec(3'd5, 32'h400, 32'h66);
    #1 chk("R3 resolved head", 64'(dc_data), 64'h66);
    chk("R3 resolved valid", 64'(dc_valid), 64'd1);
    step();
    retire_ok = 1'b0;

    // R1 fill to full, R9 wrap
    for (int k = 0; k < 8; k++) begin
      disp_valid = 1'b1;
      #1 chk("R1 fill idx", 64'(disp_idx), 64'((6 + k) % 8));
      step();
    end
    #1 chk("R1 full", 64'(disp_ready), 64'd0);
    step();
    disp_valid = 1'b0;
    #1 chk("R1 full no alloc", 64'(disp_idx), 64'd6);
    chk("R9 pos", 64'(disp_pos), 64'd14);
    for (int k = 0; k < 8; k++) begin
      do_exec(IDXW'((6 + k) % 8), 32'h500, DW'(32'h70 + k));
    end
    search("R9 wrap mid", 1'b0, 32'h500, 4'd9, 1'b1, 1'b0, 32'h72);
    search("R9 wrap all", 1'b0, 32'h500, 4'd14, 1'b1, 1'b0, 32'h77);
    search("R9 wrap none", 1'b0, 32'h500, 4'd6, 1'b0, 1'b0, 32'h0);

    // R10 clear
    retire_ok = 1'b1; clear = 1'b1;
    step();
    clear = 1'b0;
    #1 chk("R10 ready", 64'(disp_ready), 64'd1);
    chk("R10 dc_valid", 64'(dc_valid), 64'd0);
    chk("R10 idx", 64'(disp_idx), 64'd0);
    search("R10 no hit", 1'b0, 32'h500, 4'd0, 1'b0, 1'b0, 32'h0);
    retire_ok = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule